// File: doc/BRIEF.md
# Master Serial Result Transmitter

This block sends an 18-bit conversion result to a host over a serial link on which it is the clock master. It drives the serial clock, the serial data line and a frame qualifier (sync). A single-cycle start pulse begins a conversion. The conversion engine is not part of the block and is modelled as a busy phase of fixed length. Two live inputs, usually tied off at board level, set the polarity of the serial clock and of the sync output.

The block has two read timings, chosen for each conversion by a mode input that is sampled with the start pulse. In read-after-convert timing the result sampled at start is shifted out once the conversion phase ends. A two-bit divider select sets the serial clock period, and busy stays high until the last bit has left. In read-during-convert timing the result of the previous accepted conversion is shifted out at a fixed divide-by-4 rate. The shift starts together with the new conversion, and busy covers only the conversion phase. The result sampled with this start is kept and sent by a later read-during-convert conversion.

Top module: `serial_result_master`

## Requirements
- R1: Exactly 18 data bits are sent per transfer, most significant bit first. Each bit is placed on the data line while the logical serial clock is low and stays stable through the following high phase.
- R2: While no transfer is in progress, the serial clock rests at its idle level (logical low) and the data line is 0. During a transfer the logical clock gives exactly 18 high pulses.
- R3: The logical sync level is 1 for every system clock of a transfer and 0 at all other times.
- R4: sclk_o is the logical serial clock XOR inv_clk_i, and sync_o is the logical sync XOR inv_sync_i. Setting either input to 1 inverts that output, including its idle level.
- R5: In read-after-convert timing (rdc_i = 0 at start), the transfer begins 20 system clocks after the start is accepted. It sends the result_i value sampled with that start.
- R6: In read-after-convert timing, divider select d (0 to 3, sampled with start) gives a serial clock period of 2^(d+1) system clocks. The first half of each period is low and the second half is high, so a transfer lasts 36·2^d clocks.
- R7: In read-after-convert timing, busy_o rises one clock after the accepted start and falls in the same cycle as sync. Its total length is 20 + 36·2^d clocks.
- R8: In read-during-convert timing (rdc_i = 1 at start), the transfer begins in the cycle after the accepted start, uses a fixed period of 4 clocks and lasts 72 clocks. busy_o is high for exactly 20 clocks.
- R9: A read-during-convert transfer sends the result sampled by the previous accepted start, in either timing. If there has been no accepted start since reset, it sends all zeros.
- R10: A start pulse that arrives while busy_o is high or a transfer is in progress is ignored. It does not begin a conversion or a transfer, and it does not change the stored result.
- R11: After reset, busy_o is 0, the data line is 0, and the clock and sync outputs are at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion pulse |
| result_i | input | 18 | Conversion result word, sampled with an accepted start |
| rdc_i | input | 1 | Read timing select: 1 read-during-convert, 0 read-after-convert |
| div_sel_i | input | 2 | Serial clock divider select for read-after-convert timing |
| inv_clk_i | input | 1 | Inverts the serial clock output |
| inv_sync_i | input | 1 | Inverts the sync output |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data, most significant bit first |
| sync_o | output | 1 | Frame qualifier, active while data is valid |
| busy_o | output | 1 | Conversion (and, in read-after-convert timing, transfer) in progress |

## Verification
The assertions check on every cycle that:
- data holds steady except at a falling edge of the logical clock;
- the clock sits at its idle level outside a transfer;
- the shifter is never reloaded while it is active;
- a read-after-convert transfer starts only as the conversion ends, and its busy falls together with the transfer;
- a read-during-convert transfer starts together with the conversion.

Only the bench scenarios can show that the right word comes out in the right order for each mode. The same holds for the divider-dependent periods and for the measured busy lengths. They also show the zero word after reset, and that ignored start pulses leave both the traffic and the stored result untouched.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sclk_phase_e;
endpackage

// File: rtl/srm_conv_timer.sv
module srm_conv_timer #(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic run_o,
    output logic done_o
);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (go_i && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o  = st_q.run;
    assign done_o = st_q.run && (st_q.cnt == LAST);

    // R7 / R8: the conversion phase ends only after its full length
    assert_conv_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(st_q.cnt) == LAST);
endmodule

// File: rtl/srm_shifter.sv
module srm_shifter
    import srm_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [DIV_W-1:0]  hsel_i,
    output logic              active_o,
    output logic              phase_o,
    output logic              sdata_o
);
    localparam int CNT_W = (1 << DIV_W) - 1;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        sclk_phase_e       phase;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DIV_W-1:0]  hsel;
        logic [DATA_W-1:0] shreg;
    } sh_t;

    sh_t st_d, st_q;
    logic [CNT_W-1:0] half_m1;

    // half period minus one: 2^hsel - 1
    assign half_m1 = {CNT_W{1'b1}} >> (CNT_W - int'(st_q.hsel));

    always_comb begin
        st_d = st_q;
        if (load_i && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.phase  = PH_LOW;
            st_d.cnt    = '0;
            st_d.bitn   = '0;
            st_d.hsel   = hsel_i;
            st_d.shreg  = word_i;
        end else if (st_q.active) begin
            if (st_q.cnt == half_m1) begin
                st_d.cnt = '0;
                if (st_q.phase == PH_LOW) begin
                    st_d.phase = PH_HIGH;
                end else begin
                    st_d.phase = PH_LOW;
                    if (st_q.bitn == LAST_BIT) begin
                        st_d.active = 1'b0;
                        st_d.shreg  = '0;
                    end else begin
                        st_d.bitn  = st_q.bitn + 1'b1;
                        st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign phase_o  = st_q.active && (st_q.phase == PH_HIGH);
    assign sdata_o  = st_q.active && st_q.shreg[DATA_W-1];

    // R10: a new word is never requested while a transfer is running
    assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !st_q.active);

    // R1: data moves only where the logical clock falls
    assert_data_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active) &&
         !(st_q.phase == PH_LOW && $past(st_q.phase) == PH_HIGH))
        |-> $stable(st_q.shreg[DATA_W-1]));
endmodule

// File: rtl/serial_result_master.sv
module serial_result_master
    import srm_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int DIV_W       = 2,
    parameter int CONV_CYCLES = 20,
    parameter int RDC_HSEL    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              rdc_i,
    input  logic [DIV_W-1:0]  div_sel_i,
    input  logic              inv_clk_i,
    input  logic              inv_sync_i,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              sync_o,
    output logic              busy_o
);
    localparam logic [DIV_W-1:0] RDC_SEL = DIV_W'(RDC_HSEL);

    typedef struct packed {
        rd_mode_e          mode;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] last_word;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             conv_run, conv_done;
    logic             sh_active, sh_phase, sh_data;
    logic             accept, load;
    logic [DIV_W-1:0] hsel;

    assign accept = start_i && !conv_run && !sh_active;
    assign load   = (accept && rdc_i) ||
                    (conv_done && st_q.mode == RD_AFTER);
    assign hsel   = accept ? RDC_SEL : st_q.div;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.mode      = rd_mode_e'(rdc_i);
            st_d.div       = div_sel_i;
            st_d.last_word = result_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    srm_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (accept),
        .run_o  (conv_run),
        .done_o (conv_done)
    );

    srm_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .word_i   (st_q.last_word),
        .hsel_i   (hsel),
        .active_o (sh_active),
        .phase_o  (sh_phase),
        .sdata_o  (sh_data)
    );

    assign sclk_o  = sh_phase ^ inv_clk_i;
    assign sync_o  = sh_active ^ inv_sync_i;
    assign sdata_o = sh_data;
    assign busy_o  = conv_run || (sh_active && st_q.mode == RD_AFTER);

    // R2: no clock activity outside a transfer
    assert_idle_sclk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_active |-> sclk_o == inv_clk_i);

    // R5: a read-after transfer starts exactly as the conversion finishes
    assert_rac_after_conv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sh_active) && st_q.mode == RD_AFTER) |-> ($past(conv_run) && !conv_run));

    // R8: a read-during transfer starts together with its conversion
    assert_rdc_with_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sh_active) && st_q.mode == RD_DURING) |-> $rose(conv_run));

    // R7: read-after busy ends with the last bit
    assert_rac_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && st_q.mode == RD_AFTER) |-> $fell(sh_active));
endmodule

// File: tb/serial_result_master_test.sv
module serial_result_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [17:0] result_i = '0;
    logic        rdc_i = 1'b0;
    logic [1:0]  div_sel_i = '0;
    logic        inv_clk = 1'b0;
    logic        inv_sync = 1'b0;
    logic        sclk_o, sdata_o, sync_o, busy_o;

    int errors = 0;
    int checks = 0;
    int done_xfers = 0;
    logic [17:0] model_last = '0;

    logic [17:0] exp_word_q[$];
    int          exp_len_q[$];

    always #4 clk = ~clk;

    serial_result_master uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .result_i(result_i),
        .rdc_i(rdc_i), .div_sel_i(div_sel_i), .inv_clk_i(inv_clk),
        .inv_sync_i(inv_sync), .sclk_o(sclk_o), .sdata_o(sdata_o),
        .sync_o(sync_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // monitor: decodes logical clock and sync, compares against the queue
    initial begin
        bit prev_clk = 0, prev_sync = 0, lclk, lsync, held = 0;
        logic [17:0] word = '0;
        int bits = 0, len = 0, stab = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_clk = 0; prev_sync = 0;
                continue;
            end
            lclk  = sclk_o ^ inv_clk;
            lsync = sync_o ^ inv_sync;
            if (lsync && !prev_sync) begin
                bits = 0; len = 0; stab = 0; word = '0;
            end
            if (lsync) begin
                len++;
                if (lclk && !prev_clk) begin
                    word = {word[16:0], sdata_o};
                    held = sdata_o;
                    bits++;
                end else if (lclk && sdata_o != held) begin
                    stab++;
                end
            end else begin
                check(sdata_o == 1'b0 && !lclk, "R2 idle data/clock", {sdata_o, lclk}, 0);
            end
            if (!lsync && prev_sync) begin
                done_xfers++;
                if (exp_word_q.size() == 0) begin
                    check(0, "R10 unexpected transfer", word, 0);
                end else begin
                    logic [17:0] ew;
                    int el;
                    ew = exp_word_q.pop_front();
                    el = exp_len_q.pop_front();
                    check(word == ew, "R1/R9 word MSB first", word, ew);
                    check(bits == 18, "R2 clock pulse count", bits, 18);
                    check(len == el, "R3/R6 sync length", len, el);
                    check(stab == 0, "R1 data stable while clock high", stab, 0);
                end
            end
            prev_clk  = lclk;
            prev_sync = lsync;
        end
    end

    // driver: one conversion, optional junk start at cycle ign_at
    task automatic do_conv(input bit rdc, input logic [1:0] div, input logic [17:0] w, input int ign_at);
        int per, exp_busy, exp_first, n, first, busylen, late_busy;
        bit lsync;
        per       = rdc ? 4 : (2 << div);
        exp_busy  = rdc ? 20 : 20 + 18 * per;
        exp_first = rdc ? 0 : 20;
        exp_word_q.push_back(rdc ? model_last : w);
        exp_len_q.push_back(18 * per);
        model_last = w;
        @(negedge clk);
        start_i = 1'b1; rdc_i = rdc; div_sel_i = div; result_i = w;
        @(negedge clk);
        start_i = 1'b0; result_i = '1;
        n = 0; first = -1; busylen = -1; late_busy = 0;
        while (n < 2000) begin
            lsync = sync_o ^ inv_sync;
            if (n == ign_at) begin
                start_i = 1'b1; result_i = ~w;
            end else begin
                start_i = 1'b0;
            end
            if (lsync && first < 0) first = n;
            if (busylen >= 0 && busy_o) late_busy++;
            if (!busy_o && busylen < 0) busylen = n;
            if (!lsync && first >= 0 && busylen >= 0) break;
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(first == exp_first, rdc ? "R8 transfer start" : "R5 transfer start", first, exp_first);
        check(busylen == exp_busy, rdc ? "R8 busy length" : "R7 busy length", busylen, exp_busy);
        check(late_busy == 0, "R10 busy stays low after ignored start", late_busy, 0);
        repeat (25) begin
            @(negedge clk);
            late_busy += ((sync_o ^ inv_sync) || busy_o) ? 1 : 0;
        end
        check(late_busy == 0, "R10 no activity after transfer", late_busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy_o == 1'b0, "R11 busy after reset", busy_o, 0);
        check(sdata_o == 1'b0, "R11 data after reset", sdata_o, 0);
        check(sclk_o == 1'b0, "R11 clock idle after reset", sclk_o, 0);
        check(sync_o == 1'b0, "R11 sync idle after reset", sync_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_conv(1'b1, 2'd0, 18'h2A5C3, -1);  // R9: zeros first
        do_conv(1'b0, 2'd0, 18'h3C0F1, -1);  // R5 R6 d=0
        do_conv(1'b0, 2'd3, 18'h15A96, -1);  // R6 d=3
        do_conv(1'b1, 2'd2, 18'h0F0F0, 30);  // R8, junk start mid-transfer (R10)
        do_conv(1'b1, 2'd1, 18'h3FFFF, -1);  // R9/R10: stored word unchanged
        // R4 inversion
        inv_clk = 1'b1; inv_sync = 1'b1;
        @(negedge clk);
        check(sclk_o == 1'b1, "R4 inverted clock idle", sclk_o, 1);
        check(sync_o == 1'b1, "R4 inverted sync idle", sync_o, 1);
        do_conv(1'b0, 2'd2, 18'h20001, -1);
        inv_clk = 1'b0; inv_sync = 1'b0;
        do_conv(1'b0, 2'd1, 18'h1B3D7, 5);   // R10 junk start during conversion
        do_conv(1'b1, 2'd0, 18'h00000, -1);  // expects 1B3D7

        repeat (5) @(negedge clk);
        check(done_xfers == 8, "R10 transfer count", done_xfers, 8);
        check(exp_word_q.size() == 0, "R2 all transfers seen", exp_word_q.size(), 0);
        finish_run();
    end
endmodule